// File: doc/BRIEF.md
# Station Address PROM Access Window

This block is the host-facing front end of a network controller. It keeps the 16-byte station-address PROM and decodes every host access that arrives through either an I/O-space window or a memory-space window. Each access is 1, 2 or 4 bytes wide. The block serves it from the PROM, forwards it to the controller's register file over a request/response port, or drops it. Dropped reads return all ones across the access width.

A configuration load sets two bits. The first selects 32-bit I/O mode, which changes the set of PROM accesses that the I/O window accepts. The second allows writes to the PROM. PROM accesses finish in a single cycle. A forwarded access holds the host side until the register file accepts the write, or until it returns the read data.

Top module: `sta_prom_window`

## Requirements
- R1: On reset, every PROM byte i takes bits 8i+7:8i of parameter PROM_INIT. 32-bit I/O mode and PROM write enable both clear to 0, hostReady is 1, and hostRvalid and regReqValid are 0.
- R2: The low four address bits select a PROM byte. Multi-byte PROM data is little-endian: the byte at offset a goes on bits 7:0, the byte at a+1 on bits 15:8, and so on. Offsets wrap modulo 16.
- R3: A PROM write changes the PROM only while the write-enable bit is 1. PROM reads are never gated.
- R4: In the I/O window (hostSpace=0) with 32-bit mode off, offsets 0x00-0x0F accept byte accesses at any offset and word accesses at even offsets. Any other access there is rejected: a read returns all ones of its width and a write has no effect.
- R5: In the I/O window with 32-bit mode on, the only access accepted at offsets 0x00-0x0F is a dword at an offset that is a multiple of 4. Every other access there is rejected as in R4.
- R6: In the I/O window, word and dword accesses at offsets 0x10 and above are forwarded with the offset unchanged. Byte accesses there are ignored, and a byte read returns 0xFF.
- R7: In the memory window (hostSpace=1), address bit 4 clear selects the PROM at offset addr[3:0] for any size code 0-2, whatever the 32-bit mode. Bit 4 set forwards word and dword accesses with offset addr[3:0].
- R8: In the memory window, a byte access with address bit 4 set is ignored, and a byte read returns 0xFF.
- R9: A forwarded request holds regReqValid, offset, size, direction and write data steady until regReqReady is seen. hostReady stays 0 from acceptance until the write handshake completes or the read response has been taken.
- R10: A PROM read or a rejected read raises hostRvalid one cycle after acceptance. A forwarded read raises hostRvalid one cycle after regRspValid, carrying regRspData masked to the access width. Writes never raise hostRvalid.
- R11: The size codes are 0=byte, 1=word and 2=dword. Code 3 is unsupported: it has no effect, and a read with it returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Loads both configuration bits |
| cfgDwordIn | input | 1 | New value of the 32-bit I/O mode bit |
| cfgPromWeIn | input | 1 | New value of the PROM write-enable bit |
| hostValid | input | 1 | Host access request |
| hostReady | output | 1 | Block can accept an access |
| hostSpace | input | 1 | 0 = I/O window, 1 = memory window |
| hostAddr | input | ADDR_W | Access offset within the window |
| hostSize | input | 2 | Size code (0 byte, 1 word, 2 dword) |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostWdata | input | 32 | Write data, little-endian lanes |
| hostRvalid | output | 1 | Read data valid strobe |
| hostRdata | output | 32 | Read data, upper unused lanes zero |
| regReqValid | output | 1 | Forwarded request valid |
| regReqReady | input | 1 | Register file accepts the request |
| regReqOffset | output | ADDR_W | Forwarded offset |
| regReqSize | output | 2 | Forwarded size code |
| regReqWrite | output | 1 | Forwarded direction |
| regReqWdata | output | 32 | Forwarded write data |
| regRspValid | input | 1 | Forwarded read data valid |
| regRspData | input | 32 | Forwarded read data |

## Verification
The hardest situations to reach are the mode-dependent rejections at PROM offsets. For example, an odd-offset word write that must leave the PROM untouched while writes are enabled, or a byte read that is legal one moment and returns 0xFF after a switch to 32-bit mode. Observing them also needs a later read that proves nothing changed. The stimulus reloads the configuration bits at random points in a long random mix of windows, offsets, sizes and directions. Every write is later read back against a byte-level model of the PROM. Directed cases add the address wrap past offset 15, stalled handshakes on the register port and the unsupported size code.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int BUS_BYTES  = 4;
  localparam int BUS_W      = 8 * BUS_BYTES;
  localparam int PROM_DEPTH = 16;
  localparam int IDX_W      = $clog2(PROM_DEPTH);

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} fwdStateT;

  typedef struct packed {
    logic [BUS_BYTES-1:0] promLaneWr;
    logic [IDX_W-1:0]     promBase;
    logic                 rdFromProm;
    logic                 rdOnes;
    logic                 rdFromRsp;
    logic                 latchReq;
    logic                 useLatchedSize;
  } ctrlStrobeT;
endpackage

// File: rtl/spw_ctrl.sv
module spw_ctrl
  import spw_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgDwordIn,
  input  logic              cfgPromWeIn,
  input  logic              hostValid,
  input  logic              hostSpace,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic              hostWrite,
  input  logic              regReqReady,
  input  logic              regRspValid,
  input  logic              reqWrite,
  output logic              hostReady,
  output logic              regReqValid,
  output ctrlStrobeT        strobe
);
  fwdStateT state, stateNext;
  logic dwordMode, promWe;
  logic isIo, promHit, promLegal, fwdLegal, accept, multiByte;
  logic [BUS_BYTES-1:0] laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwordMode <= 1'b0;
      promWe    <= 1'b0;
    end else if (cfgLoad) begin
      dwordMode <= cfgDwordIn;
      promWe    <= cfgPromWeIn;
    end
  end

  always_comb begin
    isIo      = !hostSpace;
    multiByte = (hostSize == SZ_WORD) || (hostSize == SZ_DWORD);
    promHit   = isIo ? (hostAddr < ADDR_W'(PROM_DEPTH)) : !hostAddr[IDX_W];
    if (isIo)
      promLegal = (!dwordMode && hostSize == SZ_BYTE)
               || (!dwordMode && hostSize == SZ_WORD && !hostAddr[0])
               || (dwordMode && hostSize == SZ_DWORD && hostAddr[1:0] == 2'b00);
    else
      promLegal = (hostSize == SZ_BYTE) || multiByte;
    fwdLegal = !promHit && multiByte;
    accept   = hostValid && (state == ST_IDLE);
    case (hostSize)
      SZ_BYTE:  laneMask = 4'b0001;
      SZ_WORD:  laneMask = 4'b0011;
      default:  laneMask = 4'b1111;
    endcase
  end

  always_comb begin
    strobe.promLaneWr     = (accept && hostWrite && promHit && promLegal && promWe)
                            ? laneMask : '0;
    strobe.promBase       = hostAddr[IDX_W-1:0];
    strobe.rdFromProm     = accept && !hostWrite && promHit && promLegal;
    strobe.rdOnes         = accept && !hostWrite && !(promHit ? promLegal : fwdLegal);
    strobe.latchReq       = accept && fwdLegal;
    strobe.rdFromRsp      = (state == ST_WAIT) && regRspValid;
    strobe.useLatchedSize = (state == ST_WAIT);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.latchReq) stateNext = ST_REQ;
      ST_REQ:  if (regReqReady) stateNext = reqWrite ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (regRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hostReady   = (state == ST_IDLE);
  assign regReqValid = (state == ST_REQ);

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdFromProm, strobe.rdOnes, strobe.latchReq, strobe.rdFromRsp})); // R10
  AST_WAIT_UNTIL_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !regRspValid) |=> !hostReady); // R9
endmodule

// File: rtl/spw_datapath.sv
module spw_datapath
  import spw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [8*PROM_DEPTH-1:0] PROM_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic              hostSpace,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic              hostWrite,
  input  logic [BUS_W-1:0]  hostWdata,
  input  logic [BUS_W-1:0]  regRspData,
  output logic              hostRvalid,
  output logic [BUS_W-1:0]  hostRdata,
  output logic [ADDR_W-1:0] reqOffset,
  output logic [1:0]        reqSize,
  output logic              reqWrite,
  output logic [BUS_W-1:0]  reqWdata
);
  logic [7:0]       promMem [PROM_DEPTH];
  logic [IDX_W-1:0] laneIdx [BUS_BYTES];
  logic [BUS_W-1:0] promRd, widthMask;
  logic [1:0]       maskSize;

  for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
    assign laneIdx[j]      = strobe.promBase + IDX_W'(j);
    assign promRd[8*j +: 8] = promMem[laneIdx[j]];
  end

  always_comb begin
    maskSize = strobe.useLatchedSize ? reqSize : hostSize;
    case (maskSize)
      SZ_BYTE: widthMask = BUS_W'(32'h0000_00FF);
      SZ_WORD: widthMask = BUS_W'(32'h0000_FFFF);
      default: widthMask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PROM_DEPTH; i++) promMem[i] <= PROM_INIT[8*i +: 8];
    end else begin
      for (int j = 0; j < BUS_BYTES; j++)
        if (strobe.promLaneWr[j]) promMem[laneIdx[j]] <= hostWdata[8*j +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRvalid <= 1'b0;
      hostRdata  <= '0;
    end else begin
      hostRvalid <= strobe.rdFromProm || strobe.rdOnes || strobe.rdFromRsp;
      if (strobe.rdFromProm)     hostRdata <= promRd & widthMask;
      else if (strobe.rdOnes)    hostRdata <= widthMask;
      else if (strobe.rdFromRsp) hostRdata <= regRspData & widthMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOffset <= '0;
      reqSize   <= SZ_BYTE;
      reqWrite  <= 1'b0;
      reqWdata  <= '0;
    end else if (strobe.latchReq) begin
      reqOffset <= hostSpace ? ADDR_W'(hostAddr[IDX_W-1:0]) : hostAddr;
      reqSize   <= hostSize;
      reqWrite  <= hostWrite;
      reqWdata  <= hostWdata;
    end
  end

  AST_RSP_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdFromRsp && reqSize == SZ_BYTE |=> hostRdata[BUS_W-1:8] == '0); // R10
endmodule

// File: rtl/sta_prom_window.sv
module sta_prom_window
  import spw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [8*PROM_DEPTH-1:0] PROM_INIT = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgDwordIn,
  input  logic              cfgPromWeIn,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              hostSpace,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic              hostWrite,
  input  logic [31:0]       hostWdata,
  output logic              hostRvalid,
  output logic [31:0]       hostRdata,
  output logic              regReqValid,
  input  logic              regReqReady,
  output logic [ADDR_W-1:0] regReqOffset,
  output logic [1:0]        regReqSize,
  output logic              regReqWrite,
  output logic [31:0]       regReqWdata,
  input  logic              regRspValid,
  input  logic [31:0]       regRspData
);
  ctrlStrobeT strobe;

  spw_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDwordIn(cfgDwordIn),
    .cfgPromWeIn(cfgPromWeIn), .hostValid(hostValid), .hostSpace(hostSpace),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWrite(hostWrite),
    .regReqReady(regReqReady), .regRspValid(regRspValid), .reqWrite(regReqWrite),
    .hostReady(hostReady), .regReqValid(regReqValid), .strobe(strobe)
  );

  spw_datapath #(.ADDR_W(ADDR_W), .PROM_INIT(PROM_INIT)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostSpace(hostSpace),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWrite(hostWrite),
    .hostWdata(hostWdata), .regRspData(regRspData), .hostRvalid(hostRvalid),
    .hostRdata(hostRdata), .reqOffset(regReqOffset), .reqSize(regReqSize),
    .reqWrite(regReqWrite), .reqWdata(regReqWdata)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    regReqValid && !regReqReady |=> regReqValid && $stable(regReqOffset)
      && $stable(regReqWdata) && $stable(regReqSize)); // R9
  AST_IO_PROM_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && !hostSpace && hostAddr < ADDR_W'(PROM_DEPTH) |=> !regReqValid); // R6
  AST_REG_BYTE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && !hostWrite && hostSize == SZ_BYTE
      && (hostSpace ? hostAddr[IDX_W] : hostAddr >= ADDR_W'(PROM_DEPTH))
      |=> hostRvalid && hostRdata == 32'h0000_00FF); // R8
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && hostWrite |=> !hostRvalid); // R10
  AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && !hostWrite && hostSize == 2'd3
      |=> hostRvalid && hostRdata == 32'hFFFF_FFFF); // R11
endmodule

// File: tb/test_sta_prom_window.sv
`timescale 1ns/1ps
module test_sta_prom_window;
  localparam logic [127:0] INIT = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgLoad = 0, cfgDwordIn = 0, cfgPromWeIn = 0;
  logic hostValid = 0, hostSpace = 0, hostWrite = 0;
  logic [4:0] hostAddr = '0;
  logic [1:0] hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic regReqReady = 0, regRspValid = 0;
  logic [31:0] regRspData = '0;
  logic hostReady, hostRvalid, regReqValid, regReqWrite;
  logic [31:0] hostRdata, regReqWdata;
  logic [4:0] regReqOffset;
  logic [1:0] regReqSize;

  int nTests = 0, nFails = 0;
  bit done = 0;
  logic [7:0] promM [16];
  bit mDw = 0, mWe = 0;

  always #4 clk = ~clk;

  sta_prom_window #(.ADDR_W(5), .PROM_INIT(INIT)) i_sta_prom_window (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDwordIn(cfgDwordIn),
    .cfgPromWeIn(cfgPromWeIn), .hostValid(hostValid), .hostReady(hostReady),
    .hostSpace(hostSpace), .hostAddr(hostAddr), .hostSize(hostSize),
    .hostWrite(hostWrite), .hostWdata(hostWdata), .hostRvalid(hostRvalid),
    .hostRdata(hostRdata), .regReqValid(regReqValid), .regReqReady(regReqReady),
    .regReqOffset(regReqOffset), .regReqSize(regReqSize), .regReqWrite(regReqWrite),
    .regReqWdata(regReqWdata), .regRspValid(regRspValid), .regRspData(regRspData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(logic [1:0] sz);
    case (sz)
      2'd0: return 32'h0000_00FF;
      2'd1: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // 0 = PROM access, 1 = rejected/ignored, 2 = forwarded
  function automatic int kindOf(bit sp, logic [4:0] a, logic [1:0] sz);
    if (sz == 2'd3) return 1;
    if (!sp) begin
      if (a < 5'd16) begin
        if (!mDw && sz == 2'd0) return 0;
        if (!mDw && sz == 2'd1 && !a[0]) return 0;
        if (mDw && sz == 2'd2 && a[1:0] == 2'b00) return 0;
        return 1;
      end
      return (sz == 2'd0) ? 1 : 2;
    end
    if (!a[4]) return 0;
    return (sz == 2'd0) ? 1 : 2;
  endfunction

  function automatic string tagOf(bit sp, logic [4:0] a, logic [1:0] sz, bit wr);
    if (sz == 2'd3) return "R11";
    if (!sp && a < 5'd16) return wr ? "R3/R4/R5" : (mDw ? "R5" : "R4");
    if (!sp) return "R6";
    if (!a[4]) return wr ? "R3/R7" : "R2/R7";
    return (sz == 2'd0) ? "R8" : "R7";
  endfunction

  function automatic logic [31:0] promRead(logic [4:0] a, logic [1:0] sz);
    logic [31:0] v = '0;
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int j = 0; j < n; j++) v[8*j +: 8] = promM[(a + j) & 15];
    return v;
  endfunction

  task automatic setCfg(input bit dw, input bit we);
    @(negedge clk);
    cfgLoad = 1; cfgDwordIn = dw; cfgPromWeIn = we;
    @(negedge clk);
    cfgLoad = 0;
    mDw = dw; mWe = we;
  endtask

  task automatic access(input bit sp, input logic [4:0] a, input logic [1:0] sz,
                        input bit wr, input logic [31:0] wd);
    int k = kindOf(sp, a, sz);
    string tag = tagOf(sp, a, sz, wr);
    logic [31:0] exp, rsp;
    @(negedge clk);
    check(hostReady == 1'b1, "R9 ready before access", 32'(hostReady), 1);
    hostValid = 1; hostSpace = sp; hostAddr = a; hostSize = sz; hostWrite = wr; hostWdata = wd;
    @(negedge clk);
    hostValid = 0;
    if (k == 2) begin
      check(regReqValid == 1'b1, {tag, " forwarded"}, 32'(regReqValid), 1);
      exp = sp ? 32'(a[3:0]) : 32'(a);
      check(32'(regReqOffset) == exp, {tag, " offset"}, 32'(regReqOffset), exp);
      check(regReqSize == sz && regReqWrite == wr, {tag, " size/dir"},
            {28'd0, regReqSize, 1'b0, regReqWrite}, {28'd0, sz, 1'b0, wr});
      if (wr) check(regReqWdata == wd, {tag, " wdata"}, regReqWdata, wd);
      repeat ($urandom % 4) begin
        @(negedge clk);
        check(regReqValid && !hostReady, "R9 hold until ready", 32'(regReqValid), 1);
      end
      regReqReady = 1;
      @(negedge clk);
      regReqReady = 0;
      check(regReqValid == 1'b0, "R9 request dropped after handshake", 32'(regReqValid), 0);
      if (wr) begin
        check(hostReady == 1'b1, "R9 ready after write handshake", 32'(hostReady), 1);
        check(hostRvalid == 1'b0, "R10 no rvalid on write", 32'(hostRvalid), 0);
      end else begin
        repeat ($urandom % 4) begin
          check(hostRvalid == 1'b0 && hostReady == 1'b0, "R9/R10 waiting for response",
                32'(hostRvalid), 0);
          @(negedge clk);
        end
        rsp = $urandom;
        regRspValid = 1; regRspData = rsp;
        @(negedge clk);
        regRspValid = 0;
        exp = rsp & maskOf(sz);
        check(hostRvalid == 1'b1, "R10 forwarded rvalid", 32'(hostRvalid), 1);
        check(hostRdata == exp, "R10 forwarded data", hostRdata, exp);
      end
    end else begin
      check(regReqValid == 1'b0, {tag, " not forwarded"}, 32'(regReqValid), 0);
      if (wr) begin
        check(hostRvalid == 1'b0, "R10 no rvalid on write", 32'(hostRvalid), 0);
        if (k == 0 && mWe)
          for (int j = 0; j < ((sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4); j++)
            promM[(a + j) & 15] = wd[8*j +: 8];
      end else begin
        exp = (k == 0) ? promRead(a, sz) : maskOf(sz);
        check(hostRvalid == 1'b1, {tag, " rvalid"}, 32'(hostRvalid), 1);
        check(hostRdata == exp, {tag, " read data"}, hostRdata, exp);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < 16; i++) promM[i] = INIT[8*i +: 8];
    repeat (3) @(negedge clk);
    check(hostReady && !hostRvalid && !regReqValid, "R1 reset outputs",
          {29'd0, hostReady, hostRvalid, regReqValid}, 32'd4);
    rstN = 1;
    // R1: initial PROM content and default config (byte reads accepted, writes dropped)
    for (int i = 0; i < 16; i++) access(0, 5'(i), 2'd0, 0, 0);
    access(0, 5'd3, 2'd0, 1, 32'h5A);
    access(0, 5'd3, 2'd0, 0, 0);                    // R1 write enable cleared
    setCfg(0, 1);
    access(0, 5'd4, 2'd1, 1, 32'hBEEF);             // R3 word write, even offset
    access(0, 5'd4, 2'd1, 0, 0);
    access(0, 5'd5, 2'd1, 1, 32'h1234);             // R4 odd word write rejected
    access(0, 5'd5, 2'd1, 0, 0);                    // R4 read returns 0xFFFF
    access(0, 5'd0, 2'd2, 0, 0);                    // R4 dword rejected in 16-bit mode
    setCfg(1, 1);
    access(0, 5'd8, 2'd2, 1, 32'hCAFEF00D);         // R5 aligned dword
    access(0, 5'd8, 2'd2, 0, 0);
    access(0, 5'd6, 2'd2, 0, 0);                    // R5 misaligned dword
    access(0, 5'd2, 2'd1, 0, 0);                    // R5 word rejected
    access(0, 5'd1, 2'd0, 1, 32'h77);               // R5 byte write ignored
    access(0, 5'd1, 2'd0, 0, 0);
    access(1, 5'd14, 2'd2, 0, 0);                   // R2 wrap across offset 15
    access(1, 5'd13, 2'd1, 1, 32'hA55A);            // R7 mode not checked
    access(1, 5'd13, 2'd1, 0, 0);
    access(1, 5'h13, 2'd0, 0, 0);                   // R8 byte to register half
    access(1, 5'h12, 2'd1, 1, 32'h0000_1357);       // R7 forwarded offset 2
    access(0, 5'h14, 2'd0, 0, 0);                   // R6 byte ignored
    access(0, 5'h12, 2'd2, 0, 0);                   // R6 forwarded read
    access(0, 5'h03, 2'd3, 0, 0);                   // R11 unsupported size
    setCfg(0, 0);
    access(1, 5'd2, 2'd1, 1, 32'h9999);             // R3 write gated
    access(1, 5'd2, 2'd1, 0, 0);
    for (int it = 0; it < 400; it++) begin
      logic [1:0] sz;
      if (it % 25 == 0) setCfg(1'($urandom), 1'($urandom));
      sz = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      access(1'($urandom), 5'($urandom), sz, 1'($urandom), $urandom);
    end
    for (int i = 0; i < 16; i++) access(1, 5'(i), 2'd0, 0, 0);  // R2/R3 final contents
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule